// File: doc/BRIEF.md
# Atomic Sequence Deferral Unit

This unit sits between a single request link and a shared memory module. Each request names the processor that issued it. It also carries a flag marking it as part of an indivisible sequence, plus an address, a write flag and write data. When a flagged request reaches memory while no sequence is open, the issuing processor becomes the owner of the module. The owner's requests then keep flowing straight to memory. Requests from every other processor are still accepted, but they are parked in an internal queue in arrival order. The owner's first request with the flag clear closes the sequence, and the parked requests are then replayed to memory.

Both sides use a valid/ready handshake. A request moves on a side when valid and ready are both high at a rising clock edge. The input side is held off (`in_ready` low) in three cases: when memory is not ready on the direct path, when the queue is full and the presented request is not from the owner, and while parked requests are being replayed. The memory side carries the requester identifier with every request, and responses are routed back with that tag. The bench expects a sender to hold a request stable until it is taken. It also expects each processor to have at most one request waiting in the queue at a time, as a processor that waits for each response would.

Top module: `atomic_defer_unit`

## Requirements
- R1: With no owner and an empty queue, the presented input request appears on the memory side in the same cycle, with `in_ready` equal to `mem_ready`, and with identifier, flag, address, write flag and data unchanged.
- R2: A request with `in_lock`=1 that reaches memory while there is no owner makes its identifier the owner.
- R3: While an owner is recorded, the owner's requests are sent to memory directly, ahead of any queued requests.
- R4: While an owner is recorded, a request from any other identifier is accepted into the queue when there is room, does not reach memory, and is later issued in arrival order.
- R5: An owner's request with `in_lock`=0 that reaches memory clears ownership, and the queued requests are then issued in order.
- R6: With no owner and a non-empty queue, the oldest queued request is presented to memory and `in_ready` stays low until the queue is empty.
- R7: A queued request with its flag at 1 starts a new owned sequence when it is issued, and that new owner's later input then bypasses the remaining queue.
- R8: With the queue full (DEPTH entries), `in_ready` is low for a request from a non-owner, while a request from the owner is still accepted.
- R9: While `mem_ready` is low, a presented memory request stays valid with unchanged fields and no request is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input request valid |
| in_ready | output | 1 | Input request accepted this cycle when high with in_valid |
| in_id | input | ID_W | Requesting processor identifier |
| in_lock | input | 1 | Indivisible-sequence flag (1 = more of the sequence follows) |
| in_addr | input | ADDR_W | Memory address |
| in_wr | input | 1 | 1 = write, 0 = read |
| in_wdata | input | DATA_W | Write data |
| mem_valid | output | 1 | Request to memory valid |
| mem_ready | input | 1 | Memory takes the request |
| mem_id | output | ID_W | Requester tag for response routing |
| mem_lock | output | 1 | Flag of the issued request |
| mem_addr | output | ADDR_W | Address of the issued request |
| mem_wr | output | 1 | Write flag of the issued request |
| mem_wdata | output | DATA_W | Write data of the issued request |

## Verification
The bench builds the unit with a queue depth of 4, a 3-bit identifier, 8-bit addresses and 16-bit data. The shallow queue lets a single owned sequence fill the queue with four other processors. That exposes the full-queue stall for outsiders together with the owner's continued access. The 3-bit identifier gives six distinct processors in one scenario. The bench also holds `mem_ready` low on both the direct path and the replay path, to show that requests stay stable and none is dropped.

// File: rtl/adu_pkg.sv
package adu_pkg;

  // Which source feeds the memory side in a given cycle.
  typedef enum logic [1:0] {
    PATH_DIRECT = 2'd0,  // input goes straight to memory
    PATH_DEFER  = 2'd1,  // input is parked in the queue
    PATH_DRAIN  = 2'd2   // queue head goes to memory, input held
  } adu_path_e;

endpackage

// File: rtl/adu_fifo.sv
module adu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [W-1:0]                push_word,
  input  logic                        pop,
  output logic [W-1:0]                head_word,
  output logic                        empty,
  output logic                        full,
  output logic [$clog2(DEPTH+1)-1:0]  count
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  logic do_push, do_pop;

  assign do_push = push && (cnt != CW'(DEPTH));
  assign do_pop  = pop  && (cnt != '0);

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    if (p == PW'(DEPTH-1)) return '0;
    return p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_word;
  end

  assign head_word = store[rd_ptr];
  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign count     = cnt;

endmodule

// File: rtl/adu_owner.sv
module adu_owner #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,      // a request reaches memory this cycle
  input  logic [ID_W-1:0] issue_id,
  input  logic            issue_lock,
  output logic            owner_v,
  output logic [ID_W-1:0] owner_id
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_v  <= 1'b0;
      owner_id <= '0;
    end else if (issue) begin
      if (!owner_v && issue_lock) begin
        owner_v  <= 1'b1;
        owner_id <= issue_id;
      end else if (owner_v && (issue_id == owner_id) && !issue_lock) begin
        owner_v  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adu_route.sv
module adu_route
  import adu_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            in_valid,
  input  logic [ID_W-1:0] in_id,
  input  logic            mem_ready,
  input  logic            owner_v,
  input  logic [ID_W-1:0] owner_id,
  input  logic            q_empty,
  input  logic            q_full,
  output adu_path_e       path,
  output logic            in_ready,
  output logic            mem_valid,
  output logic            q_push,
  output logic            q_pop
);

  always_comb begin
    if (!owner_v && !q_empty)
      path = PATH_DRAIN;
    else if (owner_v && (in_id != owner_id))
      path = PATH_DEFER;
    else
      path = PATH_DIRECT;
  end

  always_comb begin
    in_ready  = 1'b0;
    mem_valid = 1'b0;
    q_push    = 1'b0;
    q_pop     = 1'b0;
    unique case (path)
      PATH_DRAIN: begin
        mem_valid = 1'b1;
        q_pop     = mem_ready;
      end
      PATH_DEFER: begin
        in_ready = !q_full;
        q_push   = in_valid && !q_full;
      end
      default: begin
        mem_valid = in_valid;
        in_ready  = mem_ready;
      end
    endcase
  end

endmodule

// File: rtl/atomic_defer_unit.sv
module atomic_defer_unit
  import adu_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic              in_lock,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_wr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ID_W-1:0]   mem_id,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int RW      = ID_W + 1 + ADDR_W + 1 + DATA_W;
  localparam int CW      = $clog2(DEPTH+1);
  localparam int DATA_LO = 0;
  localparam int WR_BIT  = DATA_W;
  localparam int ADDR_LO = DATA_W + 1;
  localparam int LOCK_B  = ADDR_LO + ADDR_W;
  localparam int ID_LO   = LOCK_B + 1;

  logic [RW-1:0]   in_word, head_word, out_word;
  logic            q_empty, q_full, q_push, q_pop;
  logic [CW-1:0]   q_count;
  logic            owner_v;
  logic [ID_W-1:0] owner_id;
  adu_path_e       path;
  logic            issue;

  assign in_word = {in_id, in_lock, in_addr, in_wr, in_wdata};

  adu_fifo #(.W(RW), .DEPTH(DEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_word (in_word),
    .pop       (q_pop),
    .head_word (head_word),
    .empty     (q_empty),
    .full      (q_full),
    .count     (q_count)
  );

  adu_route #(.ID_W(ID_W)) i_route (
    .in_valid  (in_valid),
    .in_id     (in_id),
    .mem_ready (mem_ready),
    .owner_v   (owner_v),
    .owner_id  (owner_id),
    .q_empty   (q_empty),
    .q_full    (q_full),
    .path      (path),
    .in_ready  (in_ready),
    .mem_valid (mem_valid),
    .q_push    (q_push),
    .q_pop     (q_pop)
  );

  assign out_word = (path == PATH_DRAIN) ? head_word : in_word;

  assign mem_id    = out_word[ID_LO +: ID_W];
  assign mem_lock  = out_word[LOCK_B];
  assign mem_addr  = out_word[ADDR_LO +: ADDR_W];
  assign mem_wr    = out_word[WR_BIT];
  assign mem_wdata = out_word[DATA_LO +: DATA_W];

  assign issue = mem_valid && mem_ready;

  adu_owner #(.ID_W(ID_W)) i_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_id   (mem_id),
    .issue_lock (mem_lock),
    .owner_v    (owner_v),
    .owner_id   (owner_id)
  );

endmodule

// File: rtl/adu_checker.sv
module adu_checker #(
  parameter int ID_W = 4,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [ID_W-1:0] in_id,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [ID_W-1:0] mem_id,
  input logic            mem_lock,
  input logic            owner_v,
  input logic [ID_W-1:0] owner_id,
  input logic [CW-1:0]   q_count,
  input logic            q_full
);

  // R1
  direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_v && q_count == '0) |-> (mem_valid == in_valid && in_ready == mem_ready));

  // R2
  owner_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owner_v) |-> $past(mem_valid && mem_ready && mem_lock));

  // R4
  owner_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_v && mem_valid) |-> (mem_id == owner_id));

  // R5
  owner_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(owner_v) |-> $past(mem_valid && mem_ready && !mem_lock));

  // R6
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_v && q_count != '0) |-> (!in_ready && mem_valid));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && in_valid && !(owner_v && in_id == owner_id)) |-> !in_ready);

endmodule

bind atomic_defer_unit adu_checker #(.ID_W(ID_W), .CW(CW)) i_adu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_id     (in_id),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_id    (mem_id),
  .mem_lock  (mem_lock),
  .owner_v   (owner_v),
  .owner_id  (owner_id),
  .q_count   (q_count),
  .q_full    (q_full)
);

// File: tb/test_atomic_defer_unit.sv
`timescale 1ns/1ps
module test_atomic_defer_unit;

  localparam int ID_W = 3, ADDR_W = 8, DATA_W = 16, DEPTH = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_ready, in_lock, in_wr;
  logic [ID_W-1:0]   in_id;
  logic [ADDR_W-1:0] in_addr;
  logic [DATA_W-1:0] in_wdata;
  logic              mem_valid, mem_ready, mem_lock, mem_wr;
  logic [ID_W-1:0]   mem_id;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [ID_W-1:0]   log_id   [64];
  logic [ADDR_W-1:0] log_addr [64];
  logic              log_wr   [64];
  logic [DATA_W-1:0] log_data [64];
  int log_n;

  always #10 clk = ~clk;

  atomic_defer_unit #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH))
    i_atomic_defer_unit (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_lock(in_lock),
      .in_addr(in_addr), .in_wr(in_wr), .in_wdata(in_wdata),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_id(mem_id), .mem_lock(mem_lock),
      .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata));

  // Memory-side monitor: inputs change just after the rising edge, so the
  // falling edge shows exactly what the next rising edge will transfer.
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready && log_n < 64) begin
      log_id[log_n]   = mem_id;
      log_addr[log_n] = mem_addr;
      log_wr[log_n]   = mem_wr;
      log_data[log_n] = mem_wdata;
      log_n = log_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exp_log(input string req, input int idx, input int id, input int addr);
    check(req, 32'(log_id[idx]), 32'(id));
    check(req, 32'(log_addr[idx]), 32'(addr));
  endtask

  task automatic present(input int id, input bit lk, input int a, input bit w, input int d);
    @(posedge clk); #1;
    in_valid = 1'b1; in_id = ID_W'(id); in_lock = lk;
    in_addr = ADDR_W'(a); in_wr = w; in_wdata = DATA_W'(d);
  endtask

  task automatic send(input int id, input bit lk, input int a, input bit w, input int d);
    present(id, lk, a, w, d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset mem_valid", 32'(mem_valid), 0);
    check("R1 reset in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_passthrough();
    log_n = 0;
    send(1, 0, 8'h10, 1, 16'hAAAA);
    send(4, 0, 8'h11, 0, 16'h0);
    send(6, 0, 8'h12, 1, 16'h1234);
    settle();
    check("R1 count", 32'(log_n), 3);
    exp_log("R1 order", 0, 1, 8'h10);
    exp_log("R1 order", 1, 4, 8'h11);
    exp_log("R1 order", 2, 6, 8'h12);
    check("R1 wr flag", 32'(log_wr[0]), 1);
    check("R1 wdata", 32'(log_data[2]), 16'h1234);
    check("R1 rd flag", 32'(log_wr[1]), 0);
  endtask

  task automatic t_owned_sequence();
    log_n = 0;
    send(1, 1, 8'h20, 0, 0);   // R2 opens sequence
    send(2, 0, 8'h30, 1, 16'hB0B0);
    send(3, 0, 8'h31, 0, 0);
    @(negedge clk);
    check("R4 outsiders held back", 32'(log_n), 1);
    send(1, 1, 8'h21, 1, 16'h5555); // R3 owner bypasses queue
    send(1, 0, 8'h22, 1, 16'h6666); // R5 closes sequence
    settle();
    check("R5 count", 32'(log_n), 5);
    exp_log("R3 owner first", 1, 1, 8'h21);
    exp_log("R5 closing", 2, 1, 8'h22);
    exp_log("R4 queued order", 3, 2, 8'h30);
    exp_log("R4 queued order", 4, 3, 8'h31);
    check("R4 queued data", 32'(log_data[3]), 16'hB0B0);
  endtask

  task automatic t_queued_owner();
    log_n = 0;
    send(1, 1, 8'h40, 0, 0);
    send(2, 1, 8'h50, 0, 0);   // R7 queued opener
    send(3, 0, 8'h60, 0, 0);
    send(1, 0, 8'h41, 0, 0);
    send(2, 0, 8'h51, 0, 0);   // new owner's input bypasses P3
    settle();
    check("R7 count", 32'(log_n), 5);
    exp_log("R7 order", 2, 2, 8'h50);
    exp_log("R7 owner bypass", 3, 2, 8'h51);
    exp_log("R7 rest drained", 4, 3, 8'h60);
  endtask

  task automatic t_full_queue();
    log_n = 0;
    send(0, 1, 8'h70, 0, 0);
    for (int k = 1; k <= 4; k++) send(k, 0, 8'h70 + k, 0, 0);
    present(5, 0, 8'h75, 0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 outsider stalled when full", 32'(in_ready), 0);
    end
    present(0, 0, 8'h7F, 0, 0);
    @(negedge clk);
    check("R8 owner accepted when full", 32'(in_ready), 1);
    present(5, 0, 8'h75, 0, 0);
    @(negedge clk);
    check("R6 input held during drain", 32'(in_ready), 0);
    check("R6 head presented", 32'(mem_id), 1);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1; in_valid = 1'b0;
    settle();
    check("R8 count", 32'(log_n), 7);
    exp_log("R8 owner close", 1, 0, 8'h7F);
    for (int k = 1; k <= 4; k++) exp_log("R6 drain order", k + 1, k, 8'h70 + k);
    exp_log("R6 new after drain", 6, 5, 8'h75);
  endtask

  task automatic t_mem_stall();
    log_n = 0;
    @(posedge clk); #1; mem_ready = 1'b0;
    present(2, 0, 8'h90, 1, 16'hC0DE);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R9 held valid", 32'(mem_valid), 1);
      check("R9 held addr", 32'(mem_addr), 8'h90);
      check("R9 input stalled", 32'(in_ready), 0);
    end
    @(posedge clk); #1; mem_ready = 1'b1;
    @(negedge clk);
    check("R9 released", 32'(in_ready), 1);
    @(posedge clk); #1; in_valid = 1'b0;
    send(1, 1, 8'hA0, 0, 0);
    send(3, 0, 8'hB0, 0, 0);
    send(1, 0, 8'hA1, 0, 0);
    #1 mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 queued head held", 32'(mem_id), 3);
    check("R9 nothing issued", 32'(log_n), 3);
    @(posedge clk); #1; mem_ready = 1'b1;
    settle();
    check("R9 count", 32'(log_n), 4);
    exp_log("R9 single issue", 0, 2, 8'h90);
    exp_log("R9 drained once", 3, 3, 8'hB0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    log_n = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_id = '0; in_lock = 1'b0;
    in_addr = '0; in_wr = 1'b0; in_wdata = '0; mem_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_passthrough();
    t_owned_sequence();
    t_queued_owner();
    t_full_queue();
    t_mem_stall();
    finish_run();
  end

endmodule